// File: doc/BRIEF.md
# I2C Bus Recovery and Chain Probe

This block is the bit-level front end of an I2C master that owns a board-level chain of serial devices. It drives the open-drain SCL and SDA wires only through output-enable controls, so a wire is either pulled low by the block or left to its pull-up. When a request arrives it first brings a possibly stuck bus back to idle. It clocks SCL until the SDA line is let go, then places a START followed by a STOP.

After recovery it works out what kind of device chain is fitted. It walks a fixed, ordered list of device addresses and sends a read-addressed START to each one. The first address that acknowledges names the chain type. For an acknowledged probe, one dummy data byte is clocked in before the STOP. The result is kept, so later requests are answered at once without touching the bus.

The length of every SCL phase is set in system clocks at an input. A controller sets it so that each half-period is at least 1 us.

Top module: `i2c_chain_finder`

## Requirements
- R1: After reset both output enables are 0 (both lines released), done_o is 0, chain_type_o is 0 and both flags are 0; a line is only ever pulled low (enable 1) or released (enable 0).
- R2: After every line change the block waits phase_len_i system clocks before the next change (a value of 0 counts as 1), so every SCL high and low interval lasts at least that long and the shortest ones equal it.
- R3: Recovery pulls SCL low, releases SDA, then gives up to 9 SCL clocks and samples SDA at the end of each high phase; on the first clock that finds SDA high it drops SDA with SCL high, lowers SCL, raises SCL and releases SDA.
- R4: If SDA is still low at the end of the 9th recovery clock, the request ends with rec_fail_o = 1, chain_type_o = 0 and no address sent, after exactly 9 SCL rising edges.
- R5: Probes go in the order 0xA4, 0xA0, 0xA2; each is preceded by a recovery and sends START plus the address byte MSB first with bit 0 set to 1 (read), giving bytes 0xA5, 0xA1, 0xA3 on the wire.
- R6: The acknowledge is sampled at the end of the 9th clock with SDA released, low meaning acknowledged; after an acknowledge the block clocks 8 data bits with SDA released, gives no acknowledge of its own and then issues STOP; after no acknowledge it moves straight to the next probe.
- R7: chain_type_o holds index+1 of the first acknowledging address (1 for 0xA4, 2 for 0xA0, 3 for 0xA2); if none acknowledges, no_chain_o = 1 and chain_type_o = 0.
- R8: When the chain type is 1 (0xA4), one more recovery runs after that probe's STOP before the request completes.
- R9: With a nonzero chain type already stored, a request completes on the next cycle with no SCL or SDA activity and the stored type unchanged.
- R10: done_o is a one-cycle pulse per request; chain_type_o, no_chain_o and rec_fail_o stay unchanged until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| phase_len_i | input | PHASE_W | System clocks per SCL phase |
| sda_i | input | 1 | Sampled level of the SDA wire |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle completion pulse |
| chain_type_o | output | 2 | Stored chain type, 0 = unknown |
| no_chain_o | output | 1 | No probe address acknowledged |
| rec_fail_o | output | 1 | Bus recovery found SDA stuck low |

## Verification
The embedded properties cover several things on every cycle. A line may change only at the end of a full phase. SDA may move while SCL is high only to form START or STOP. The recovery counter never passes its limit. done_o lasts one cycle, and a stored type answers on the next cycle with the lines held. Whether the right addresses reach the wire, in order and with the read bit, is shown only by the bench. The same holds for a stuck SDA released on the 9th clock rather than the 10th, for the extra recovery after the legacy probe, and for the exact SCL edge count of each outcome. The bench shows these with a modelled device chain that can hold SDA low for a chosen number of clocks.

// File: rtl/i2c_chain_pkg.sv
package i2c_chain_pkg;

  localparam int NUM_PROBES = 3;
  localparam int REC_CLOCKS = 9;

  typedef enum logic [4:0] {
    S_IDLE, S_R_SCLLO, S_R_SDAREL, S_R_CLKHI, S_R_CLKLO,
    S_R_STA, S_R_STALO, S_R_STOHI, S_R_STOREL,
    S_S_SDALO, S_S_SCLLO, S_W_SDA, S_W_HI, S_W_LO,
    S_A_REL, S_A_HI, S_A_LO, S_D_HI, S_D_LO,
    S_P_SDALO, S_P_HI, S_P_REL, S_DONE
  } seq_state_e;

  // probe order is behaviour: the first acknowledging entry wins
  function automatic logic [7:0] probe_addr(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hA4;
      2'd1:    return 8'hA0;
      default: return 8'hA2;
    endcase
  endfunction

  function automatic logic [7:0] read_cmd(input logic [7:0] dev);
    return dev | 8'h01;
  endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kick_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               expire_o
);
  logic [PHASE_W-1:0] cnt_q;
  logic [PHASE_W-1:0] len_m1;

  assign len_m1   = (len_i == '0) ? '0 : len_i - PHASE_W'(1);
  assign expire_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (kick_i)       cnt_q <= len_m1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - PHASE_W'(1);
  end

  // R2
  kick_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |-> expire_o);

endmodule

// File: rtl/i2c_chain_seq.sv
module i2c_chain_seq
  import i2c_chain_pkg::*;
#(
  parameter int REC_LIMIT = REC_CLOCKS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sda_i,
  input  logic       expire_i,
  output logic       kick_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic [1:0] chain_o,
  output logic       no_chain_o,
  output logic       rec_fail_o
);
  localparam int CW = $clog2(REC_LIMIT + 1);

  seq_state_e state_q, state_d;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic [CW-1:0] rec_q, rec_d;
  logic [2:0]    bit_q, bit_d;
  logic [1:0]    idx_q, idx_d, chain_q, chain_d;
  logic          leg_q, leg_d, ack_q, ack_d, noch_q, noch_d, rf_q, rf_d;
  logic [7:0]    sh_q, sh_d;
  logic          cond_step;
  logic          past_ok;

  always_comb begin
    state_d = state_q; scl_d = scl_q; sda_d = sda_q; rec_d = rec_q;
    bit_d = bit_q; idx_d = idx_q; chain_d = chain_q; leg_d = leg_q;
    ack_d = ack_q; noch_d = noch_q; rf_d = rf_q; sh_d = sh_q;
    if (state_q == S_IDLE) begin
      if (start_i) begin
        noch_d = 1'b0; rf_d = 1'b0;
        if (chain_q != 2'd0) state_d = S_DONE;
        else begin
          idx_d = 2'd0; leg_d = 1'b0; scl_d = 1'b1; state_d = S_R_SCLLO;
        end
      end
    end else if (state_q == S_DONE) begin
      scl_d = 1'b0; sda_d = 1'b0; state_d = S_IDLE;
    end else if (expire_i) begin
      case (state_q)
        S_R_SCLLO:  begin sda_d = 1'b0; rec_d = '0; state_d = S_R_SDAREL; end
        S_R_SDAREL: begin scl_d = 1'b0; state_d = S_R_CLKHI; end
        S_R_CLKHI: begin
          if (sda_i) begin sda_d = 1'b1; state_d = S_R_STA; end
          else begin scl_d = 1'b1; rec_d = rec_q + CW'(1); state_d = S_R_CLKLO; end
        end
        S_R_CLKLO: begin
          if (rec_q == CW'(REC_LIMIT)) begin
            if (leg_q) chain_d = 2'd1;
            else       rf_d = 1'b1;
            state_d = S_DONE;
          end else begin scl_d = 1'b0; state_d = S_R_CLKHI; end
        end
        S_R_STA:    begin scl_d = 1'b1; state_d = S_R_STALO; end
        S_R_STALO:  begin scl_d = 1'b0; state_d = S_R_STOHI; end
        S_R_STOHI:  begin sda_d = 1'b0; state_d = S_R_STOREL; end
        S_R_STOREL: begin
          if (leg_q) begin chain_d = 2'd1; state_d = S_DONE; end
          else begin sda_d = 1'b1; state_d = S_S_SDALO; end
        end
        S_S_SDALO:  begin scl_d = 1'b1; state_d = S_S_SCLLO; end
        S_S_SCLLO: begin
          sh_d = read_cmd(probe_addr(idx_q)); bit_d = 3'd0;
          sda_d = ~sh_d[7]; state_d = S_W_SDA;
        end
        S_W_SDA:    begin scl_d = 1'b0; state_d = S_W_HI; end
        S_W_HI:     begin scl_d = 1'b1; state_d = S_W_LO; end
        S_W_LO: begin
          if (bit_q == 3'd7) begin sda_d = 1'b0; state_d = S_A_REL; end
          else begin
            bit_d = bit_q + 3'd1; sh_d = {sh_q[6:0], 1'b0};
            sda_d = ~sh_q[6]; state_d = S_W_SDA;
          end
        end
        S_A_REL:    begin scl_d = 1'b0; state_d = S_A_HI; end
        S_A_HI:     begin ack_d = ~sda_i; scl_d = 1'b1; state_d = S_A_LO; end
        S_A_LO: begin
          if (ack_q) begin bit_d = 3'd0; scl_d = 1'b0; state_d = S_D_HI; end
          else if (idx_q == 2'(NUM_PROBES - 1)) begin noch_d = 1'b1; state_d = S_DONE; end
          else begin idx_d = idx_q + 2'd1; state_d = S_R_SCLLO; end
        end
        S_D_HI:     begin scl_d = 1'b1; state_d = S_D_LO; end
        S_D_LO: begin
          if (bit_q == 3'd7) begin sda_d = 1'b1; state_d = S_P_SDALO; end
          else begin bit_d = bit_q + 3'd1; scl_d = 1'b0; state_d = S_D_HI; end
        end
        S_P_SDALO:  begin scl_d = 1'b0; state_d = S_P_HI; end
        S_P_HI:     begin sda_d = 1'b0; state_d = S_P_REL; end
        S_P_REL: begin
          if (idx_q == 2'd0) begin leg_d = 1'b1; scl_d = 1'b1; state_d = S_R_SCLLO; end
          else begin chain_d = idx_q + 2'd1; state_d = S_DONE; end
        end
        default:    state_d = S_IDLE;
      endcase
    end
  end

  assign kick_o = (state_d != state_q) && (state_d != S_DONE) && (state_d != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; scl_q <= 1'b0; sda_q <= 1'b0; rec_q <= '0;
      bit_q <= 3'd0; idx_q <= 2'd0; chain_q <= 2'd0; leg_q <= 1'b0;
      ack_q <= 1'b0; noch_q <= 1'b0; rf_q <= 1'b0; sh_q <= 8'd0;
      past_ok <= 1'b0;
    end else begin
      state_q <= state_d; scl_q <= scl_d; sda_q <= sda_d; rec_q <= rec_d;
      bit_q <= bit_d; idx_q <= idx_d; chain_q <= chain_d; leg_q <= leg_d;
      ack_q <= ack_d; noch_q <= noch_d; rf_q <= rf_d; sh_q <= sh_d;
      past_ok <= 1'b1;
    end
  end

  assign scl_oe_o   = scl_q;
  assign sda_oe_o   = sda_q;
  assign done_o     = (state_q == S_DONE);
  assign chain_o    = chain_q;
  assign no_chain_o = noch_q;
  assign rec_fail_o = rf_q;

  // steps allowed to move SDA while SCL is released: START, STOP, idle release
  assign cond_step = (state_q == S_R_STA) || (state_q == S_R_STOREL) ||
                     (state_q == S_S_SDALO) || (state_q == S_P_REL) ||
                     (state_q == S_IDLE);

  // R3
  bus_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$stable(sda_q) && !scl_q && !$past(scl_q)) |-> cond_step);

  // R4
  rec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q <= CW'(REC_LIMIT));

  // R7
  no_chain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(no_chain_o && (chain_o != 2'd0)) && !(no_chain_o && rec_fail_o));

  // R9
  cache_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && chain_q != 2'd0) |=>
      (done_o && $stable(scl_q) && $stable(sda_q) && $stable(chain_q)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/i2c_chain_finder.sv
module i2c_chain_finder
  import i2c_chain_pkg::*;
#(
  parameter int PHASE_W   = 8,
  parameter int REC_LIMIT = REC_CLOCKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_len_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic               done_o,
  output logic [1:0]         chain_type_o,
  output logic               no_chain_o,
  output logic               rec_fail_o
);
  logic kick;
  logic expire;

  i2c_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_i   (kick),
    .len_i    (phase_len_i),
    .expire_o (expire)
  );

  i2c_chain_seq #(.REC_LIMIT(REC_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sda_i      (sda_i),
    .expire_i   (expire),
    .kick_o     (kick),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .done_o     (done_o),
    .chain_o    (chain_type_o),
    .no_chain_o (no_chain_o),
    .rec_fail_o (rec_fail_o)
  );

endmodule

// File: tb/i2c_chain_finder_tb.sv
module i2c_chain_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SLV_DATA = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] phase_len = 8'd2;
  logic scl_oe, sda_oe, done, no_chain, rec_fail;
  logic [1:0] chain;
  logic scl_line, sda_line;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // modelled device chain
  logic [2:0] resp = 3'b000;
  int stuck_init = 0;
  int stuck_left = 0;
  logic slv_drv = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int st = 0;
  int bc = 0;
  logic [7:0] sh = 8'd0;
  logic [7:0] alog [0:7];
  int nlog = 0;

  // bus observation
  logic counting = 1'b0;
  int rises = 0;
  int hi_len = 0, lo_len = 0, min_hi = 0, min_lo = 0;
  logic scl_n = 1'b1;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_drv || (stuck_left > 0));

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_chain_finder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .phase_len_i  (phase_len),
    .sda_i        (sda_line),
    .scl_oe_o     (scl_oe),
    .sda_oe_o     (sda_oe),
    .done_o       (done),
    .chain_type_o (chain),
    .no_chain_o   (no_chain),
    .rec_fail_o   (rec_fail)
  );

  function automatic logic [7:0] bench_dev(input int i);
    if (i == 0) return 8'hA4;
    if (i == 1) return 8'hA0;
    return 8'hA2;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [2:0] r);
    for (int i = 0; i < 3; i++)
      if (r[i] && b == (bench_dev(i) | 8'h01)) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (!rst_n) begin
      st <= 0; slv_drv <= 1'b0; nlog <= 0; stuck_left <= stuck_init; bc <= 0;
    end else begin
      if (scl_p && !scl_line && stuck_left > 0) stuck_left <= stuck_left - 1;
      if (scl_p && scl_line && sda_p && !sda_line) begin
        st <= 1; bc <= 0; slv_drv <= 1'b0;
      end else if (scl_p && scl_line && !sda_p && sda_line) begin
        st <= 0; slv_drv <= 1'b0;
      end else if (!scl_p && scl_line) begin
        if (st == 1) begin sh <= {sh[6:0], sda_line}; bc <= bc + 1; end
      end else if (scl_p && !scl_line) begin
        if (st == 1 && bc == 8) begin
          if (nlog < 8) alog[nlog] <= sh;
          nlog <= nlog + 1;
          if (addr_hit(sh, resp)) begin slv_drv <= 1'b1; st <= 2; end
          else st <= 0;
        end else if (st == 2) begin
          st <= 3; bc <= 0; slv_drv <= !SLV_DATA[7];
        end else if (st == 3) begin
          if (bc == 7) begin slv_drv <= 1'b0; st <= 0; end
          else begin bc <= bc + 1; slv_drv <= !SLV_DATA[6 - bc]; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rises <= 0; hi_len <= -100000; lo_len <= -100000;
      min_hi <= 1000000; min_lo <= 1000000; scl_n <= 1'b1;
    end else begin
      scl_n <= scl_line;
      if (scl_line) begin
        if (!scl_n) begin
          if (counting && !done) rises <= rises + 1;
          if (lo_len > 0 && lo_len < min_lo) min_lo <= lo_len;
          hi_len <= 1;
        end else hi_len <= hi_len + 1;
      end else begin
        if (scl_n) begin
          if (hi_len > 0 && hi_len < min_hi) min_hi <= hi_len;
          lo_len <= 1;
        end else lo_len <= lo_len + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) chk(1'b0, "R10 watchdog", 0, 1);
    if (cycles > 190000) finish_run();
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic trial(input logic [2:0] r, input int k, input logic [7:0] len);
    int c, exp_rises, exp_chain, exp_n;
    bit exp_nc, exp_rf, ok;
    logic [7:0] exp_log [0:2];
    int leff, rb;
    logic [1:0] ch0;
    logic nc0, rf0;
    // expected outcome from the requirements
    leff = (len == 0) ? 1 : int'(len);
    c = (k < 1) ? 1 : k;
    exp_chain = 0; exp_nc = 1'b0; exp_rf = 1'b0; exp_n = 0;
    if (c > 9) begin
      exp_rf = 1'b1; exp_rises = 9;
    end else begin
      exp_rises = c + 1;
      exp_nc = 1'b1;
      for (int i = 0; i < 3; i++) begin
        if (i > 0) exp_rises += 2;
        exp_rises += 9;
        exp_log[exp_n] = bench_dev(i) | 8'h01;
        exp_n++;
        if (r[i]) begin
          exp_rises += 9;
          if (i == 0) exp_rises += 2;
          exp_chain = i + 1; exp_nc = 1'b0;
          break;
        end
      end
    end
    // apply
    resp = r; stuck_init = k; phase_len = len;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe && !done && chain == 2'd0 && !no_chain && !rec_fail,
        "R1 reset", {scl_oe, sda_oe, done, chain, no_chain, rec_fail}, 0);
    counting = 1'b1;
    pulse_start();
    wait_done(ok);
    counting = 1'b0;
    if (!ok) return;
    chk(chain == 2'(exp_chain), "R7 chain type", chain, exp_chain);
    chk(no_chain == exp_nc, "R7 no chain", no_chain, exp_nc);
    chk(rec_fail == exp_rf, "R4 recovery fail", rec_fail, exp_rf);
    // R3 R4 R6 R8: SCL edge count per outcome
    chk(rises == exp_rises, "R3 R6 R8 scl rises", rises, exp_rises);
    chk(nlog == exp_n, "R5 probe count", nlog, exp_n);
    for (int i = 0; i < 3; i++)
      if (i < exp_n && i < nlog)
        chk(alog[i] == exp_log[i], "R5 probe byte", alog[i], exp_log[i]);
    chk(min_hi == leff, "R2 shortest high", min_hi, leff);
    if (!exp_rf || k > 0)
      chk(min_lo == leff, "R2 shortest low", min_lo, leff);
    ch0 = chain; nc0 = no_chain; rf0 = rec_fail;
    repeat (3) @(negedge clk);
    chk(!done, "R10 done pulse", done, 0);
    chk(chain == ch0 && no_chain == nc0 && rec_fail == rf0, "R10 flags held",
        {chain, no_chain, rec_fail}, {ch0, nc0, rf0});
    if (exp_chain != 0) begin
      rb = rises;
      counting = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R9 cached answer next cycle", done, 1);
      chk(chain == 2'(exp_chain), "R9 cached type", chain, exp_chain);
      chk(!scl_oe && !sda_oe && rises == rb, "R9 no bus activity",
          {scl_oe, sda_oe}, 0);
      counting = 1'b0;
      @(negedge clk);
      chk(!done, "R10 cached done pulse", done, 0);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    // directed corner cases
    trial(3'b000, 0, 8'd2);   // R7 nobody answers
    trial(3'b001, 0, 8'd1);   // R8 legacy chain
    trial(3'b100, 9, 8'd3);   // R3 released on last recovery clock
    trial(3'b010, 10, 8'd2);  // R4 stuck for good
    trial(3'b110, 3, 8'd0);   // R2 zero length counts as one
    trial(3'b111, 1, 8'd4);   // R5 first in order wins
    for (int t = 0; t < 24; t++)
      trial(3'($urandom % 8), int'($urandom % 11), 8'(1 + $urandom % 5));
    finish_run();
  end

endmodule